// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects eight edge-triggered interrupt requests and presents them to a processor through a single interrupt line. Each rising edge on a request input is synchronized, detected and latched into a pending register. A per-line mask decides which pending requests may take part in arbitration. The mask acts on what has already been latched, so a masked request is kept and competes once its line is unmasked. Priority is fixed: line 0 ranks highest and line 7 lowest.

When the processor pulses the acknowledge strobe, the best eligible pending request leaves the pending register and enters an in-service register. In the next cycle the block returns a vector made of a programmable base and the index of the granted line. Levels in service block requests of equal or lower rank. A strictly higher request still raises the interrupt line, so several levels can be in service at once. A host command retires the highest-ranked level in service. Arbitration then runs again, so a request that was held back is not lost.

The host port is synchronous. It has three register slots: one for the mask, one for the vector base and one for commands. The block runs without automatic end-of-interrupt, without cascading and without rotating priority.

Top module: `nest_intc`

## Requirements
- R1: A rising edge on `req_in[i]` sets pending bit i three clock edges after the input rises, through a two-stage synchronizer. A line held high produces exactly one request and must return low before another edge can be latched.
- R2: Priority is fixed, with line 0 highest and line 7 lowest. Among eligible pending requests, the lowest index is granted.
- R3: A host write to address 0 loads the mask: a 1 in bit i masks line i. A masked pending request never drives `irq_out`, stays latched and becomes eligible as soon as its mask bit is cleared.
- R4: Once `irq_out` is high it stays high until an acknowledge, with no timeout. The only exception is a mask write that leaves no eligible request, which drops `irq_out`.
- R5: An acknowledge strobe with `irq_out` high moves the granted request from pending to in-service. One cycle after the strobe, `vec_valid` is high for one cycle and `vec_out` holds {base[4:0], index[2:0]}.
- R6: While any level is in service, pending requests of equal or lower priority keep `irq_out` low. A strictly higher-priority unmasked request raises it, which allows nesting.
- R7: A host write to address 2 with data bit 0 set is a non-specific end-of-interrupt. It clears only the highest-priority in-service bit.
- R8: After an end-of-interrupt, if an unmasked pending request outranks every remaining in-service level, `irq_out` rises again in the next cycle.
- R9: An acknowledge while `irq_out` is low returns the vector {base, 3'b111}. It sets no in-service bit and leaves pending requests untouched.
- R10: After reset, `irq_out`, `vec_valid` and `vec_out` are 0, the mask is 8'hFF (all lines masked) and the vector base is 0. A host write to address 1 loads the base from data bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 8 | Asynchronous interrupt request lines, rising edge active |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 2 | Host register select: 0 mask, 1 vector base, 2 command |
| host_wdata | input | 8 | Host write data |
| ack | input | 1 | Acknowledge strobe from the processor |
| irq_out | output | 1 | Interrupt request toward the processor |
| vec_out | output | 8 | Vector returned for the last acknowledge |
| vec_valid | output | 1 | High in the cycle after an acknowledge |

## Verification
A corrupt pending or in-service register shows up on `irq_out` within one cycle. A spurious or missing in-service bit either blocks a higher request or lets an equal one through. A lost pending bit shows up as an interrupt that never returns after an end-of-interrupt. A wrong grant shows in `vec_out` one cycle after the acknowledge. An end-of-interrupt that clears the wrong level becomes visible as soon as a request arrives at a rank between the remaining levels.

// File: rtl/intc_pkg.sv
// Package: shared definitions for the nested interrupt controller.
// Holds the host register map and the command bit positions.
package intc_pkg;

    // Host register select encoding; the slot numbers are what software writes.
    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_BASE = 2'd1,
        REG_CMD  = 2'd2,
        REG_NONE = 2'd3
    } intc_reg_e;

    // Bit of the command word that requests a non-specific end-of-interrupt.
    localparam int CMD_EOI_BIT = 0;

endpackage

// File: rtl/intc_edge_sync.sv
// Module: intc_edge_sync
// Brings N asynchronous request lines into the clock domain with two
// flip-flops each and flags one-cycle pulses on rising edges.
// Assumes each line stays stable for at least two clocks per level.
module intc_edge_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    // Two-stage synchronizer plus the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            // Rising edge: synchronized level high, previous sample low.
            assign rise_o[g] = sync_q[g] & ~prev_q[g];

            AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o[g] |=> !rise_o[g]); // R1
        end
    endgenerate

endmodule

// File: rtl/intc_host_regs.sv
// Module: intc_host_regs
// Decodes host writes into the mask register, the vector base and a
// one-cycle end-of-interrupt pulse. The mask resets to all lines masked.
module intc_host_regs
    import intc_pkg::*;
#(
    parameter int N      = 8,
    parameter int DATAW  = 8,
    parameter int BASEW  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [DATAW-1:0] wdata_i,
    output logic [N-1:0]     mask_o,
    output logic [BASEW-1:0] base_o,
    output logic             eoi_o
);

    intc_reg_e sel;
    logic [N-1:0]     mask_q;
    logic [BASEW-1:0] base_q;

    // Interpret the address as a register slot.
    assign sel = intc_reg_e'(addr_i);

    // Mask and base registers, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            base_q <= '0;
        end else if (wr_i) begin
            if (sel == REG_MASK) mask_q <= wdata_i[N-1:0];
            if (sel == REG_BASE) base_q <= wdata_i[BASEW-1:0];
        end
    end

    // End-of-interrupt command decode, valid in the write cycle.
    always_comb begin
        eoi_o = wr_i && (sel == REG_CMD) && wdata_i[CMD_EOI_BIT];
    end

    assign mask_o = mask_q;
    assign base_o = base_q;

endmodule

// File: rtl/intc_arbiter.sv
// Module: intc_arbiter
// Combinational fixed-priority resolver (index 0 highest). Finds the best
// unmasked pending line and the top in-service level, and decides whether
// the pending line may interrupt. Assumes registered inputs.
module intc_arbiter #(
    parameter int N    = 8,
    parameter int IDXW = 3
) (
    input  logic [N-1:0]    pend_i,
    input  logic [N-1:0]    mask_i,
    input  logic [N-1:0]    insvc_i,
    output logic            irq_o,
    output logic [IDXW-1:0] grant_idx_o,
    output logic [N-1:0]    grant_oh_o,
    output logic [N-1:0]    top_insvc_oh_o
);

    logic [N-1:0]    elig;
    logic [IDXW-1:0] best_idx;
    logic            best_vld;
    logic [IDXW-1:0] top_idx;
    logic            top_vld;

    // Mask applies to the latched requests, not to their capture.
    assign elig = pend_i & ~mask_i;

    // Lowest set index of the eligible vector.
    always_comb begin
        best_idx = '0;
        best_vld = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                best_idx = IDXW'(i);
                best_vld = 1'b1;
            end
        end
    end

    // Lowest set index of the in-service vector.
    always_comb begin
        top_idx = '0;
        top_vld = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (insvc_i[i]) begin
                top_idx = IDXW'(i);
                top_vld = 1'b1;
            end
        end
    end

    // Interrupt only when the best request outranks everything in service.
    always_comb begin
        irq_o = best_vld && (!top_vld || (best_idx < top_idx));
    end

    // One-hot forms used by the register update in the top level.
    always_comb begin
        grant_oh_o     = '0;
        top_insvc_oh_o = '0;
        if (best_vld) grant_oh_o[best_idx]    = 1'b1;
        if (top_vld)  top_insvc_oh_o[top_idx] = 1'b1;
    end

    assign grant_idx_o = best_idx;

endmodule

// File: rtl/nest_intc.sv
// Module: nest_intc (top)
// Eight-line fully nested interrupt controller with fixed priority and
// host-issued non-specific end-of-interrupt. Holds the pending and
// in-service registers and the vector output. Assumes ack is a one-cycle strobe.
module nest_intc #(
    parameter int NLINES = 8,
    parameter int VECW   = 8,
    parameter int DATAW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] req_in,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATAW-1:0]  host_wdata,
    input  logic              ack,
    output logic              irq_out,
    output logic [VECW-1:0]   vec_out,
    output logic              vec_valid
);

    localparam int IDXW  = $clog2(NLINES);
    localparam int BASEW = VECW - IDXW;

    logic [NLINES-1:0] rise;
    logic [NLINES-1:0] mask;
    logic [BASEW-1:0]  base;
    logic              eoi;
    logic              irq;
    logic [IDXW-1:0]   grant_idx;
    logic [NLINES-1:0] grant_oh;
    logic [NLINES-1:0] top_oh;
    logic [NLINES-1:0] pend_q;
    logic [NLINES-1:0] insvc_q;
    logic [VECW-1:0]   vec_q;
    logic              vec_vld_q;
    logic              take;

    intc_edge_sync #(.N(NLINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (req_in),
        .rise_o (rise)
    );

    intc_host_regs #(.N(NLINES), .DATAW(DATAW), .BASEW(BASEW)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (host_wr),
        .addr_i  (host_addr),
        .wdata_i (host_wdata),
        .mask_o  (mask),
        .base_o  (base),
        .eoi_o   (eoi)
    );

    intc_arbiter #(.N(NLINES), .IDXW(IDXW)) u_arb (
        .pend_i         (pend_q),
        .mask_i         (mask),
        .insvc_i        (insvc_q),
        .irq_o          (irq),
        .grant_idx_o    (grant_idx),
        .grant_oh_o     (grant_oh),
        .top_insvc_oh_o (top_oh)
    );

    // An acknowledge only transfers a request when one is eligible.
    assign take = ack && irq;

    // Pending register: new edges set, a granted line clears.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(take ? grant_oh : '0)) | rise;
    end

    // In-service register: grant sets, end-of-interrupt clears the top level.
    always_ff @(posedge clk) begin
        if (!rst_n) insvc_q <= '0;
        else        insvc_q <= (insvc_q & ~(eoi ? top_oh : '0)) | (take ? grant_oh : '0);
    end

    // Vector register: base plus granted index, or the lowest line when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q     <= '0;
            vec_vld_q <= 1'b0;
        end else begin
            vec_vld_q <= ack;
            if (ack) vec_q <= {base, (irq ? grant_idx : IDXW'(NLINES - 1))};
        end
    end

    assign irq_out   = irq;
    assign vec_out   = vec_q;
    assign vec_valid = vec_vld_q;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack && !host_wr) |=> irq_out); // R4

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((pend_q & ~mask) != '0)); // R3

    AST_VEC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid); // R5

    AST_GRANT_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && !eoi) |=> ($countones(insvc_q) == $countones($past(insvc_q)) + 1)); // R5

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && (insvc_q != '0)) |=> ($countones(insvc_q) == $countones($past(insvc_q)) - 1)); // R7

    AST_IDLE_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_out && !eoi) |=> (insvc_q == $past(insvc_q))); // R9

endmodule

// File: tb/sim_nest_intc.sv
// Bench for nest_intc: directed corner cases followed by seeded random
// operations, all compared against a behavioural model kept in the bench.
module sim_nest_intc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = '0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       ack = 1'b0;
    logic       irq_out;
    logic [7:0] vec_out;
    logic       vec_valid;

    int n_chk = 0;
    int n_bad = 0;

    // Model state derived from the requirements.
    logic [7:0] m_pend = '0;
    logic [7:0] m_isr  = '0;
    logic [7:0] m_mask = 8'hFF;
    logic [4:0] m_base = '0;

    always #5 clk = ~clk;

    nest_intc u0 (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .ack(ack),
        .irq_out(irq_out), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    function automatic int low_idx(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic model_irq();
        int b = low_idx(m_pend & ~m_mask);
        int t = low_idx(m_isr);
        return (b < 8) && (b < t);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic raise(input int i);
        @(negedge clk); req_in[i] = 1'b1;
        repeat (3) @(negedge clk);
        m_pend[i] = 1'b1;
    endtask

    task automatic drop(input int i);
        req_in[i] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input int i);
        raise(i);
        drop(i);
    endtask

    task automatic host(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
        if (a == 2'd0) m_mask = d;
        if (a == 2'd1) m_base = d[4:0];
        if (a == 2'd2 && d[0] && m_isr != 0) m_isr[low_idx(m_isr)] = 1'b0;
    endtask

    task automatic do_ack(input string req);
        logic [7:0] exp_vec;
        int b;
        if (model_irq()) begin
            b = low_idx(m_pend & ~m_mask);
            exp_vec = {m_base, 3'(b)};
            m_pend[b] = 1'b0;
            m_isr[b]  = 1'b1;
        end else begin
            exp_vec = {m_base, 3'd7};
        end
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        chk({req, " vec_valid"}, int'(vec_valid), 1);
        chk({req, " vec_out"}, int'(vec_out), int'(exp_vec));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 irq", int'(irq_out), 0);
        chk("R10 vec_valid", int'(vec_valid), 0);
        chk("R10 vec_out", int'(vec_out), 0);

        // R3: masked after reset, request latched but silent
        pulse(2);
        chk("R3 masked irq", int'(irq_out), 0);
        host(2'd1, 8'h15);
        host(2'd0, 8'h00);
        chk("R3 unmasked irq", int'(irq_out), 1);
        do_ack("R5 grant 2");
        chk("R10 base vec", int'(vec_out), 8'hAA);
        chk("R5 irq after ack", int'(irq_out), 0);

        // R6: lower and equal held, higher nests
        pulse(5);
        chk("R6 lower held", int'(irq_out), 0);
        pulse(2);
        chk("R6 equal held", int'(irq_out), 0);
        pulse(1);
        chk("R6 higher nests", int'(irq_out), 1);
        repeat (60) @(negedge clk);
        chk("R4 irq held without ack", int'(irq_out), 1);
        do_ack("R6 nested grant 1");

        // R7/R8: only the top level retires; held requests come back
        host(2'd2, 8'h01);
        chk("R7 only top cleared", int'(irq_out), 0);
        host(2'd2, 8'h01);
        chk("R8 re-arbitrate", int'(irq_out), 1);
        do_ack("R8 grant 2");
        chk("R8 line 5 still held", int'(irq_out), 0);
        host(2'd2, 8'h01);
        chk("R8 line 5 released", int'(irq_out), 1);
        do_ack("R8 grant 5");
        host(2'd2, 8'h01);

        // R9: idle acknowledge
        do_ack("R9 idle ack");
        chk("R9 idle vec", int'(vec_out), 8'hAF);
        pulse(4);
        chk("R9 isr untouched", int'(irq_out), 1);
        do_ack("R9 later grant 4");
        host(2'd2, 8'h01);

        // R4: masking the raising request drops irq
        pulse(6);
        chk("R4 raised", int'(irq_out), 1);
        host(2'd0, 8'h40);
        chk("R4 mask drops", int'(irq_out), 0);
        host(2'd0, 8'h00);
        chk("R3 unmask restores", int'(irq_out), 1);
        do_ack("R4 grant 6");
        host(2'd2, 8'h01);

        // R1: held-high line gives one request
        raise(3);
        do_ack("R1 grant 3");
        host(2'd2, 8'h01);
        repeat (20) @(negedge clk);
        chk("R1 held high no repeat", int'(irq_out), 0);
        drop(3);
        pulse(3);
        chk("R1 new edge after low", int'(irq_out), 1);
        do_ack("R1 regrant 3");
        host(2'd2, 8'h01);

        // R2: fixed priority among simultaneous pending
        pulse(7);
        pulse(4);
        do_ack("R2 grant 4 over 7");
        host(2'd2, 8'h01);
        do_ack("R2 grant 7");
        host(2'd2, 8'h01);

        // Random phase against the model
        for (int it = 0; it < 500; it++) begin
            int op = $urandom % 6;
            case (op)
                0, 1: pulse($urandom % 8);
                2: do_ack("R5 random ack");
                3: host(2'd2, 8'h01);
                4: host(2'd0, 8'($urandom & $urandom));
                default: repeat (2) @(negedge clk);
            endcase
            chk("R6 R8 random irq", int'(irq_out), int'(model_irq()));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule